// File: doc/BRIEF.md
# Stack-Machine Execute Unit

This block performs the execute step of a small 16-bit stack processor. A fetch stage outside the block presents an 8-bit opcode and a 16-bit argument with a one-cycle execute strobe. The unit then acts on a single working register (tmp), a wrapping 16-bit stack pointer, a private stack memory and an external register file, and it pulses a done flag when the operation has finished.

Every value travels through tmp. An immediate can be pushed straight onto the stack. tmp can be loaded from the argument, from the register file or from the top of the stack. tmp can be written to the register file or pushed onto the stack. A pop lowers the pointer and zeroes the word it leaves behind. A debug opcode parks the unit until an external continue input arrives.

The stack memory is inferred block RAM with a registered read and no reset. It is addressed by the low `STK_AW` bits of the stack pointer, 10 bits by default. The register file is outside the block: it is read through a registered index with a combinational data return and written through a one-cycle write pulse.

Top module: `stk_exec_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `done`, `dbg_halt` and `rf_wr_en` are 0, and `tmp_q` and `sp_q` are 0.
- R2: Opcode 0x01 stores `exec_arg` at stack index `sp` and then increments `sp`. `done` is high one cycle after the strobe.
- R3: Opcode 0x02 decrements `sp` and then writes zero at the new stack index. `done` is high one cycle after the strobe.
- R4: Opcode 0x03 loads `tmp_q` with `exec_arg`. `done` and the new `tmp_q` appear one cycle after the strobe.
- R5: Opcode 0x04 drives `rf_rd_idx` with `exec_arg[7:0]` one cycle after the strobe and loads `tmp_q` with `rf_rd_data` two cycles after the strobe, when `done` is high.
- R6: Opcode 0x05 loads `tmp_q` with the word at stack index `sp-1` and leaves `sp` unchanged. The result and `done` appear two cycles after the strobe.
- R7: Opcode 0x06 raises `rf_wr_en` for exactly one cycle, one cycle after the strobe, with `rf_wr_idx` = `exec_arg[7:0]` and `rf_wr_data` = `tmp_q`. `done` is high in that same cycle.
- R8: Opcode 0x08 stores `tmp_q` at stack index `sp` and then increments `sp`. `done` is high one cycle after the strobe.
- R9: Every change to `sp` wraps modulo 2^16. The stack word used is selected by the low `STK_AW` bits of the pointer, so a pop at `sp` = 0 gives 0xFFFF and a push at 0xFFFF gives 0.
- R10: Opcode 0x09 raises `dbg_halt` one cycle after the strobe. It stays high until `resume` is sampled high. One cycle after that, `dbg_halt` is 0 and `done` is high.
- R11: Opcodes 0x00, 0x07 and 0x0A to 0xFF leave `tmp_q`, `sp_q` and the register file unchanged and raise `done` one cycle after the strobe.
- R12: A strobe that arrives while an operation is still in progress (register read wait, stack read wait or debug halt) is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_valid | input | 1 | Execute strobe |
| exec_op | input | 8 | Opcode |
| exec_arg | input | 16 | Instruction argument |
| resume | input | 1 | Continue input that ends a debug halt |
| done | output | 1 | One-cycle completion pulse |
| dbg_halt | output | 1 | High while parked on the debug opcode |
| tmp_q | output | 16 | Working register |
| sp_q | output | 16 | Stack pointer |
| rf_rd_idx | output | 8 | Register file read index |
| rf_rd_data | input | 16 | Register file read data (combinational from index) |
| rf_wr_en | output | 1 | Register file write pulse |
| rf_wr_idx | output | 8 | Register file write index |
| rf_wr_data | output | 16 | Register file write data |

## Verification
Immediate loads, pushes, pops, register writes and undefined opcodes are due one clock edge after the strobe edge. Register and stack loads are due two edges after it, and the end of a debug halt is due one edge after `resume` is sampled. The bench raises the strobe at a falling edge and then counts rising edges, sampling 1 ns after each one until `done` appears. It compares that count with the latency stated for the opcode and checks `tmp_q`, `sp_q` and the register write port at the same instant against its own stack and register models.

// File: rtl/stk_exec_pkg.sv
package stk_exec_pkg;
  localparam int OP_W = 8;

  localparam logic [OP_W-1:0] OPC_PUSH_ARG = 8'h01;
  localparam logic [OP_W-1:0] OPC_POP      = 8'h02;
  localparam logic [OP_W-1:0] OPC_LD_IMM   = 8'h03;
  localparam logic [OP_W-1:0] OPC_LD_REG   = 8'h04;
  localparam logic [OP_W-1:0] OPC_LD_TOP   = 8'h05;
  localparam logic [OP_W-1:0] OPC_ST_REG   = 8'h06;
  localparam logic [OP_W-1:0] OPC_PUSH_TMP = 8'h08;
  localparam logic [OP_W-1:0] OPC_BREAK    = 8'h09;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RF_WAIT,
    ST_STK_WAIT,
    ST_HALT
  } exec_st_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic src_tmp;
    logic ld_imm;
    logic ld_rf;
    logic ld_stk;
    logic st_rf;
    logic brk;
  } exec_ctl_t;
endpackage

// File: rtl/stk_decode.sv
module stk_decode
  import stk_exec_pkg::*;
(
  input  logic [OP_W-1:0] op,
  output exec_ctl_t       ctl
);
  always_comb begin
    ctl = '0;
    case (op)
      OPC_PUSH_ARG: ctl.push = 1'b1;
      OPC_POP:      ctl.pop = 1'b1;
      OPC_LD_IMM:   ctl.ld_imm = 1'b1;
      OPC_LD_REG:   ctl.ld_rf = 1'b1;
      OPC_LD_TOP:   ctl.ld_stk = 1'b1;
      OPC_ST_REG:   ctl.st_rf = 1'b1;
      OPC_PUSH_TMP: begin
        ctl.push    = 1'b1;
        ctl.src_tmp = 1'b1;
      end
      OPC_BREAK:    ctl.brk = 1'b1;
      default:      ctl = '0;
    endcase
  end
endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int SP_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inc,
  input  logic            dec,
  output logic [SP_W-1:0] sp_q,
  output logic [SP_W-1:0] sp_m1
);
  assign sp_m1 = sp_q - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= '0;
    end else if (inc) begin
      sp_q <= sp_q + 1'b1;
    end else if (dec) begin
      sp_q <= sp_m1;
    end
  end
endmodule

// File: rtl/stk_ram.sv
module stk_ram #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/stk_exec_unit.sv
module stk_exec_unit
  import stk_exec_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SP_W   = 16,
  parameter int STK_AW = 10,
  parameter int RIDX_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exec_valid,
  input  logic [OP_W-1:0]   exec_op,
  input  logic [DATA_W-1:0] exec_arg,
  input  logic              resume,
  output logic              done,
  output logic              dbg_halt,
  output logic [DATA_W-1:0] tmp_q,
  output logic [SP_W-1:0]   sp_q,
  output logic [RIDX_W-1:0] rf_rd_idx,
  input  logic [DATA_W-1:0] rf_rd_data,
  output logic              rf_wr_en,
  output logic [RIDX_W-1:0] rf_wr_idx,
  output logic [DATA_W-1:0] rf_wr_data
);
  exec_st_t          st;
  exec_ctl_t         ctl;
  logic              st_idle;
  logic              accept;
  logic [SP_W-1:0]   sp_m1;
  logic              stk_we;
  logic [STK_AW-1:0] stk_waddr;
  logic [DATA_W-1:0] stk_wdata;
  logic [DATA_W-1:0] stk_rdata;

  assign st_idle = (st == ST_IDLE);
  assign accept  = exec_valid && st_idle;

  stk_decode u_dec (
    .op  (exec_op),
    .ctl (ctl)
  );

  stk_ptr #(.SP_W(SP_W)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .inc   (accept && ctl.push),
    .dec   (accept && ctl.pop),
    .sp_q  (sp_q),
    .sp_m1 (sp_m1)
  );

  assign stk_we    = accept && (ctl.push || ctl.pop);
  assign stk_waddr = ctl.pop ? sp_m1[STK_AW-1:0] : sp_q[STK_AW-1:0];
  assign stk_wdata = ctl.pop ? '0 : (ctl.src_tmp ? tmp_q : exec_arg);

  stk_ram #(.AW(STK_AW), .DW(DATA_W)) u_ram (
    .clk   (clk),
    .we    (stk_we),
    .waddr (stk_waddr),
    .wdata (stk_wdata),
    .raddr (sp_m1[STK_AW-1:0]),
    .rdata (stk_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      done       <= 1'b0;
      dbg_halt   <= 1'b0;
      tmp_q      <= '0;
      rf_rd_idx  <= '0;
      rf_wr_en   <= 1'b0;
      rf_wr_idx  <= '0;
      rf_wr_data <= '0;
    end else begin
      done     <= 1'b0;
      rf_wr_en <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (exec_valid) begin
            if (ctl.ld_imm) begin
              tmp_q <= exec_arg;
              done  <= 1'b1;
            end else if (ctl.ld_rf) begin
              rf_rd_idx <= exec_arg[RIDX_W-1:0];
              st        <= ST_RF_WAIT;
            end else if (ctl.ld_stk) begin
              st <= ST_STK_WAIT;
            end else if (ctl.st_rf) begin
              rf_wr_en   <= 1'b1;
              rf_wr_idx  <= exec_arg[RIDX_W-1:0];
              rf_wr_data <= tmp_q;
              done       <= 1'b1;
            end else if (ctl.brk) begin
              dbg_halt <= 1'b1;
              st       <= ST_HALT;
            end else begin
              done <= 1'b1;
            end
          end
        end
        ST_RF_WAIT: begin
          tmp_q <= rf_rd_data;
          done  <= 1'b1;
          st    <= ST_IDLE;
        end
        ST_STK_WAIT: begin
          tmp_q <= stk_rdata;
          done  <= 1'b1;
          st    <= ST_IDLE;
        end
        ST_HALT: begin
          if (resume) begin
            dbg_halt <= 1'b0;
            done     <= 1'b1;
            st       <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stk_exec_chk.sv
module stk_exec_chk #(
  parameter int DATA_W = 16,
  parameter int SP_W   = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              exec_valid,
  input logic [7:0]        exec_op,
  input logic [DATA_W-1:0] exec_arg,
  input logic              resume,
  input logic              done,
  input logic              dbg_halt,
  input logic [DATA_W-1:0] tmp_q,
  input logic [SP_W-1:0]   sp_q,
  input logic              rf_wr_en,
  input logic [DATA_W-1:0] rf_wr_data,
  input logic              idle
);
  logic acc;
  assign acc = exec_valid && idle;

  // R2
  push_inc_chk: assert property (@(posedge clk) disable iff (rst)
    acc && (exec_op == 8'h01 || exec_op == 8'h08) |=> sp_q == $past(sp_q) + 1'b1 && done);

  // R3
  pop_dec_chk: assert property (@(posedge clk) disable iff (rst)
    acc && exec_op == 8'h02 |=> sp_q == $past(sp_q) - 1'b1 && done);

  // R4
  ld_imm_chk: assert property (@(posedge clk) disable iff (rst)
    acc && exec_op == 8'h03 |=> tmp_q == $past(exec_arg) && done);

  // R7
  rf_write_chk: assert property (@(posedge clk) disable iff (rst)
    acc && exec_op == 8'h06 |=> rf_wr_en && rf_wr_data == $past(tmp_q));

  // R7
  rf_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rf_wr_en |=> !rf_wr_en);

  // R10
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dbg_halt && !resume |=> dbg_halt && !done);

  // R12
  sp_still_chk: assert property (@(posedge clk) disable iff (rst)
    !(acc && (exec_op == 8'h01 || exec_op == 8'h02 || exec_op == 8'h08)) |=> $stable(sp_q));
endmodule

bind stk_exec_unit stk_exec_chk #(.DATA_W(DATA_W), .SP_W(SP_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .exec_valid (exec_valid),
  .exec_op    (exec_op),
  .exec_arg   (exec_arg),
  .resume     (resume),
  .done       (done),
  .dbg_halt   (dbg_halt),
  .tmp_q      (tmp_q),
  .sp_q       (sp_q),
  .rf_wr_en   (rf_wr_en),
  .rf_wr_data (rf_wr_data),
  .idle       (st_idle)
);

// File: tb/stk_exec_unit_bench.sv
`timescale 1ns/1ps
module stk_exec_unit_bench;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        exec_valid = 1'b0;
  logic [7:0]  exec_op = '0;
  logic [15:0] exec_arg = '0;
  logic        resume = 1'b0;
  logic        done, dbg_halt, rf_wr_en;
  logic [15:0] tmp_q, sp_q, rf_rd_data, rf_wr_data;
  logic [7:0]  rf_rd_idx, rf_wr_idx;

  logic [15:0] rf_mem [0:255];
  logic [15:0] m_stk [0:DEPTH-1];
  logic [15:0] m_sp, m_tmp;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  stk_exec_unit #(.STK_AW(AW)) u_stk_exec_unit (
    .clk(clk), .rst(rst), .exec_valid(exec_valid), .exec_op(exec_op),
    .exec_arg(exec_arg), .resume(resume), .done(done), .dbg_halt(dbg_halt),
    .tmp_q(tmp_q), .sp_q(sp_q), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data)
  );

  assign rf_rd_data = rf_mem[rf_rd_idx];
  always @(posedge clk) if (rf_wr_en) rf_mem[rf_wr_idx] <= rf_wr_data;

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [7:0] op);
    case (op)
      8'h01: return "R2";
      8'h02: return "R3";
      8'h03: return "R4";
      8'h04: return "R5";
      8'h05: return "R6";
      8'h06: return "R7";
      8'h08: return "R8";
      default: return "R11";
    endcase
  endfunction

  // issue one non-halting opcode, update the model, check latency, tmp and sp
  task automatic run_op(input logic [7:0] op, input logic [15:0] arg);
    int lat;
    int exp_lat;
    string tag;
    tag = op_tag(op);
    exp_lat = (op == 8'h04 || op == 8'h05) ? 2 : 1;
    case (op)
      8'h01: begin m_stk[m_sp[AW-1:0]] = arg; m_sp = m_sp + 16'd1; end
      8'h02: begin m_sp = m_sp - 16'd1; m_stk[m_sp[AW-1:0]] = 16'h0000; end
      8'h03: m_tmp = arg;
      8'h04: m_tmp = rf_mem[arg[7:0]];
      8'h05: m_tmp = m_stk[(m_sp - 16'd1) & 16'(DEPTH - 1)];
      8'h08: begin m_stk[m_sp[AW-1:0]] = m_tmp; m_sp = m_sp + 16'd1; end
      default: ;
    endcase
    @(negedge clk);
    exec_valid = 1'b1; exec_op = op; exec_arg = arg;
    @(posedge clk); #1;
    exec_valid = 1'b0;
    lat = 1;
    while (!done && lat < 6) begin
      @(posedge clk); #1;
      lat++;
    end
    chk(tag, "latency", 16'(lat), 16'(exp_lat));
    chk(tag, "tmp", tmp_q, m_tmp);
    chk(tag, "sp", sp_q, m_sp);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) rf_mem[i] = 16'(i * 257) ^ 16'h5A00;
    m_sp = 16'h0000; m_tmp = 16'h0000;
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk("R1", "done", {15'd0, done}, 16'd0);
    chk("R1", "halt", {15'd0, dbg_halt}, 16'd0);
    chk("R1", "wr_en", {15'd0, rf_wr_en}, 16'd0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk("R1", "tmp", tmp_q, 16'h0000);
    chk("R1", "sp", sp_q, 16'h0000);
    chk("R1", "done", {15'd0, done}, 16'd0);

    // R4: immediate loads
    run_op(8'h03, 16'h0000);
    run_op(8'h03, 16'hFFFF);
    run_op(8'h03, 16'hA5C3);
    run_op(8'h03, 16'h8001);

    // R7 then R5 over every register index
    for (int i = 0; i < 256; i++) begin
      logic [15:0] v;
      v = 16'(i * 40503 + 7);
      run_op(8'h03, v);
      run_op(8'h06, 16'(i) | 16'hC300);
      chk("R7", "wr_en", {15'd0, rf_wr_en}, 16'd1);
      chk("R7", "wr_idx", {8'd0, rf_wr_idx}, 16'(i));
      chk("R7", "wr_data", rf_wr_data, v);
      @(posedge clk); #1;
      chk("R7", "wr_en drop", {15'd0, rf_wr_en}, 16'd0);
      run_op(8'h03, 16'h0000);
      run_op(8'h04, 16'(i) | 16'h3300);
      chk("R5", "rd_idx", {8'd0, rf_rd_idx}, 16'(i));
      chk("R5", "value", tmp_q, v);
    end

    // R2 and R6: pushes with peeks
    for (int k = 1; k <= 8; k++) begin
      run_op(8'h01, 16'(k * 16'h1111));
      run_op(8'h05, 16'h0000);
    end
    // R8: push tmp
    run_op(8'h03, 16'hBEEF);
    run_op(8'h08, 16'h0000);
    run_op(8'h03, 16'h0000);
    run_op(8'h05, 16'h0000);
    chk("R8", "top", tmp_q, 16'hBEEF);
    // R3: pop down to zero, peeking below each time
    for (int k = 0; k < 9; k++) begin
      run_op(8'h02, 16'h0000);
      if (m_sp != 16'h0000) run_op(8'h05, 16'h0000);
    end
    // R9: wrap both ways
    run_op(8'h02, 16'h0000);
    chk("R9", "sp wrap down", sp_q, 16'hFFFF);
    run_op(8'h01, 16'h7E57);
    chk("R9", "sp wrap up", sp_q, 16'h0000);
    run_op(8'h05, 16'h0000);
    chk("R9", "top at last index", tmp_q, 16'h7E57);
    // R3: cleared word seen again through index aliasing
    run_op(8'h02, 16'h0000);
    for (int k = 0; k < DEPTH - 1; k++) run_op(8'h02, 16'h0000);
    run_op(8'h05, 16'h0000);
    chk("R3", "cleared word", tmp_q, 16'h0000);

    // R10 and R12: debug halt
    run_op(8'h03, 16'h4242);
    @(negedge clk);
    exec_valid = 1'b1; exec_op = 8'h09; exec_arg = 16'h0000;
    @(posedge clk); #1;
    exec_valid = 1'b0;
    chk("R10", "halt raised", {15'd0, dbg_halt}, 16'd1);
    chk("R10", "no done", {15'd0, done}, 16'd0);
    @(negedge clk);
    exec_valid = 1'b1; exec_op = 8'h03; exec_arg = 16'h1234;
    @(negedge clk);
    exec_op = 8'h01;
    @(negedge clk);
    exec_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R10", "halt held", {15'd0, dbg_halt}, 16'd1);
    chk("R12", "tmp ignored", tmp_q, 16'h4242);
    chk("R12", "sp ignored", sp_q, m_sp);
    @(negedge clk); resume = 1'b1;
    @(posedge clk); #1;
    resume = 1'b0;
    chk("R10", "halt cleared", {15'd0, dbg_halt}, 16'd0);
    chk("R10", "done", {15'd0, done}, 16'd1);
    @(posedge clk); #1;
    chk("R10", "done pulse", {15'd0, done}, 16'd0);

    // R11: every undefined opcode
    for (int op = 0; op < 256; op++) begin
      if (op == 0 || op == 7 || op >= 10) begin
        run_op(8'(op), 16'(op * 613 + 1));
        chk("R11", "no rf write", {15'd0, rf_wr_en}, 16'd0);
      end
    end
    run_op(8'h05, 16'h0000);
    chk("R11", "stack intact", tmp_q, 16'h0000);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule